// File: doc/BRIEF.md
# In-Order Completion Buffer

This block keeps a circular record of in-flight instructions in program order. A dispatch stage writes an instruction's tag into the slot at the tail and gets that slot's index back. Each execution unit later reports by index that its instruction has finished. Every cycle the buffer hands out, oldest first, the tags of the instructions it retires. An instruction retires only when it has finished and every older instruction has already retired. Free and used counts, and a stall flag, let dispatch hold off when no slot is left.

Each slot is a small state machine. The states are `SLOT_IDLE` (empty), `SLOT_WAIT` (allocated, still executing) and `SLOT_DONE` (finished, waiting its turn). Three transitions connect them. *take* (IDLE to WAIT) happens when dispatch writes the slot. *finish* (WAIT to DONE) happens when a completion port names the slot. *drain* (DONE to IDLE) happens when the slot retires. The buffer as a whole tracks occupancy with a second machine with three states: `OCC_EMPTY`, `OCC_SOME` and `OCC_FULL`. Its *fill* and *empty* moves follow the net change in the used count, and being in `OCC_FULL` raises the dispatch stall.

The retire scan looks at up to five slots, starting at the head. It stops at the first slot that is not in `SLOT_DONE`, or when no allocated entries remain. All retired slots are freed at the same clock edge.

Top module: `completion_buffer`

## Requirements
- R1: After reset, used_cnt is 0, free_cnt is 16, dispatch_stall is 0, no ret_valid bit is set, and alloc_idx is 0.
- R2: An accepted allocation stores alloc_tag in the slot shown on alloc_idx in that cycle. At the next edge it raises used_cnt by one, lowers free_cnt by one, and advances alloc_idx by one modulo 16.
- R3: A completion (cmpl_valid[p] with slot number cmpl_idx[p*4 +: 4]) marks a waiting slot finished. A completion that names an empty slot or an already finished slot has no effect. Both completion ports may act in the same cycle.
- R4: Retired tags come out in allocation order, with the oldest on lane 0 (ret_tags[7:0]) and lane k on ret_tags[k*8 +: 8]. The scan stops at the first unfinished entry, so younger finished entries wait behind it.
- R5: No more than five entries retire in one cycle. ret_count equals the number of set ret_valid bits, and those bits are contiguous from lane 0. Any surplus of finished entries retires in later cycles.
- R6: A completion taken at a clock edge shows on the retire lanes in the cycle right after that edge, and not before it.
- R7: An allocation request while free_cnt is 0 is dropped. alloc_err is high in that same cycle, and used_cnt, free_cnt and alloc_idx do not change because of it.
- R8: dispatch_stall is high exactly when free_cnt is 0.
- R9: When an allocation and retirements happen in the same cycle, used_cnt changes by one minus the number retired, and free_cnt changes by the opposite amount.
- R10: free_cnt plus used_cnt is always 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_tag | input | 8 | Tag of the dispatched instruction |
| alloc_idx | output | 4 | Slot the next accepted allocation will use |
| alloc_err | output | 1 | Allocation requested while full (dropped) |
| cmpl_valid | input | 2 | One finish strobe per completion port |
| cmpl_idx | input | 8 | Slot number per completion port, 4 bits each |
| ret_valid | output | 5 | Retire lanes active this cycle, lane 0 oldest |
| ret_tags | output | 40 | Retired tags, 8 bits per lane |
| ret_count | output | 3 | Number of entries retiring this cycle |
| free_cnt | output | 5 | Empty slots |
| used_cnt | output | 5 | Occupied slots |
| dispatch_stall | output | 1 | No slot is free |

## Verification
Allocation at the tail and retirement at the head can land on the same clock edge, so both counters must absorb two opposite updates at once. The bench provokes this with directed runs that keep allocating while a batch of finished entries drains, and with a long random run that mixes allocation and out-of-order completion. In every cycle, a bench model that applies retire, then finish, then take to the state before the edge predicts the counts, the retire lanes and the tail index. The run also covers the case where a full buffer refuses an allocation in the same cycle that it starts to drain.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_DONE = 2'd2
    } slot_st_e;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_SOME  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_st_e;

endpackage

// File: rtl/cbuf_slot.sv
module cbuf_slot
    import cbuf_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [TAG_W-1:0] take_tag,
    input  logic             finish,
    input  logic             drain,
    output slot_st_e         st,
    output logic [TAG_W-1:0] tag,
    output logic             is_done
);

    slot_st_e st_n;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SLOT_IDLE;
        else        st <= st_n;
    end

    // transitions: take, finish, drain
    always_comb begin
        st_n = st;
        unique case (st)
            SLOT_IDLE: if (take)   st_n = SLOT_WAIT;
            SLOT_WAIT: if (finish) st_n = SLOT_DONE;
            SLOT_DONE: if (drain)  st_n = SLOT_IDLE;
            default:               st_n = SLOT_IDLE;
        endcase
    end

    // tag payload: loaded on take, cleared on drain
    always_ff @(posedge clk) begin
        if (!rst_n)                         tag <= '0;
        else if (st == SLOT_IDLE && take)   tag <= take_tag;
        else if (st == SLOT_DONE && drain)  tag <= '0;
    end

    // outputs
    always_comb begin
        is_done = (st == SLOT_DONE);
    end

    AST_TAKE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) take |-> st == SLOT_IDLE); // R2
    AST_DRAIN_DONE:  assert property (@(posedge clk) disable iff (!rst_n) drain |-> st == SLOT_DONE); // R4
    AST_FINISH_MARK: assert property (@(posedge clk) disable iff (!rst_n) (finish && st == SLOT_WAIT) |=> st == SLOT_DONE); // R3
    AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (finish && !take && st == SLOT_IDLE) |=> st == SLOT_IDLE); // R3

endmodule

// File: rtl/cbuf_drain.sv
module cbuf_drain #(
    parameter int DEPTH = 16,
    parameter int RET_W = 5,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int RNW   = $clog2(RET_W + 1)
) (
    input  logic [DEPTH-1:0]       done_vec,
    input  logic [DEPTH*TAG_W-1:0] tags_flat,
    input  logic [IDX_W-1:0]       head,
    input  logic [CNT_W-1:0]       used,
    output logic [DEPTH-1:0]       drain_vec,
    output logic [RET_W-1:0]       ret_valid,
    output logic [RET_W*TAG_W-1:0] ret_tags,
    output logic [RNW-1:0]         ret_n
);

    logic [IDX_W-1:0] pick;
    logic             run;

    // scan from the head; stop at first unfinished slot or when entries run out
    always_comb begin
        run       = 1'b1;
        pick      = head;
        drain_vec = '0;
        ret_valid = '0;
        ret_tags  = '0;
        ret_n     = '0;
        for (int k = 0; k < RET_W; k++) begin
            pick = IDX_W'((int'(head) + k) % DEPTH);
            run  = run && (k < int'(used)) && done_vec[pick];
            if (run) begin
                drain_vec[pick]              = 1'b1;
                ret_valid[k]                 = 1'b1;
                ret_tags[k*TAG_W +: TAG_W]   = tags_flat[int'(pick)*TAG_W +: TAG_W];
                ret_n                        = ret_n + RNW'(1);
            end
        end
    end

    AST_RET_CONTIG: assert final ((ret_valid & (ret_valid + RET_W'(1))) == '0); // R5

endmodule

// File: rtl/cbuf_ptrs.sv
module cbuf_ptrs
    import cbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int RET_W = 5,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int RNW   = $clog2(RET_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [RNW-1:0]   pop_n,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] used,
    output logic [CNT_W-1:0] free,
    output logic             full
);

    occ_st_e          occ, occ_n;
    logic [CNT_W-1:0] used_n;

    always_comb begin
        used_n = used + CNT_W'(push) - CNT_W'(pop_n);
    end

    // pointer and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= '0;
            used <= '0;
            free <= CNT_W'(DEPTH);
        end else begin
            head <= head + IDX_W'(pop_n);
            tail <= tail + IDX_W'(push);
            used <= used_n;
            free <= free - CNT_W'(push) + CNT_W'(pop_n);
        end
    end

    // occupancy state register
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= OCC_EMPTY;
        else        occ <= occ_n;
    end

    // occupancy transitions: fill and empty
    always_comb begin
        occ_n = occ;
        unique case (occ)
            OCC_EMPTY: if (used_n != '0)
                           occ_n = (used_n == CNT_W'(DEPTH)) ? OCC_FULL : OCC_SOME;
            OCC_SOME:  if (used_n == '0)                occ_n = OCC_EMPTY;
                       else if (used_n == CNT_W'(DEPTH)) occ_n = OCC_FULL;
            OCC_FULL:  if (used_n != CNT_W'(DEPTH))
                           occ_n = (used_n == '0) ? OCC_EMPTY : OCC_SOME;
            default:   occ_n = OCC_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        full = (occ == OCC_FULL);
    end

    AST_COUNT_SUM:   assert property (@(posedge clk) disable iff (!rst_n) ({1'b0, free} + {1'b0, used}) == (CNT_W+1)'(DEPTH)); // R10
    AST_FULL_STALL:  assert property (@(posedge clk) disable iff (!rst_n) full == (free == '0)); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (used == CNT_W'(DEPTH)) |-> !push); // R7
    AST_POP_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) (CNT_W'(pop_n) <= used) && (int'(pop_n) <= RET_W)); // R5
    AST_HEAD_STEP:   assert property (@(posedge clk) disable iff (!rst_n) rst_n && $past(rst_n) |-> head == $past(head) + IDX_W'($past(pop_n))); // R4

endmodule

// File: rtl/completion_buffer.sv
module completion_buffer
    import cbuf_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int RET_W      = 5,
    parameter int TAG_W      = 8,
    parameter int CMPL_PORTS = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int RNW   = $clog2(RET_W + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_valid,
    input  logic [TAG_W-1:0]            alloc_tag,
    output logic [IDX_W-1:0]            alloc_idx,
    output logic                        alloc_err,
    input  logic [CMPL_PORTS-1:0]       cmpl_valid,
    input  logic [CMPL_PORTS*IDX_W-1:0] cmpl_idx,
    output logic [RET_W-1:0]            ret_valid,
    output logic [RET_W*TAG_W-1:0]      ret_tags,
    output logic [RNW-1:0]              ret_count,
    output logic [CNT_W-1:0]            free_cnt,
    output logic [CNT_W-1:0]            used_cnt,
    output logic                        dispatch_stall
);

    logic [IDX_W-1:0]       head, tail;
    logic                   full, push;
    logic [RNW-1:0]         pop_n;
    logic [DEPTH-1:0]       done_vec, drain_vec, take_vec, finish_vec;
    logic [DEPTH*TAG_W-1:0] tags_flat;

    always_comb begin
        push      = alloc_valid && !full;
        alloc_err = alloc_valid && full;
    end

    cbuf_ptrs #(.DEPTH(DEPTH), .RET_W(RET_W)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop_n (pop_n),
        .head  (head),
        .tail  (tail),
        .used  (used_cnt),
        .free  (free_cnt),
        .full  (full)
    );

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        slot_st_e st_s;

        always_comb begin
            take_vec[s]   = push && (tail == IDX_W'(s));
            finish_vec[s] = 1'b0;
            for (int p = 0; p < CMPL_PORTS; p++)
                if (cmpl_valid[p] && cmpl_idx[p*IDX_W +: IDX_W] == IDX_W'(s))
                    finish_vec[s] = 1'b1;
        end

        cbuf_slot #(.TAG_W(TAG_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .take     (take_vec[s]),
            .take_tag (alloc_tag),
            .finish   (finish_vec[s]),
            .drain    (drain_vec[s]),
            .st       (st_s),
            .tag      (tags_flat[s*TAG_W +: TAG_W]),
            .is_done  (done_vec[s])
        );
    end

    cbuf_drain #(.DEPTH(DEPTH), .RET_W(RET_W), .TAG_W(TAG_W)) u_drain (
        .done_vec  (done_vec),
        .tags_flat (tags_flat),
        .head      (head),
        .used      (used_cnt),
        .drain_vec (drain_vec),
        .ret_valid (ret_valid),
        .ret_tags  (ret_tags),
        .ret_n     (pop_n)
    );

    always_comb begin
        alloc_idx      = tail;
        ret_count      = pop_n;
        dispatch_stall = full;
    end

    AST_ERR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n) alloc_err |-> free_cnt == '0); // R7
    AST_FULL_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) alloc_err |=> alloc_idx == $past(alloc_idx)); // R7
    AST_EMPTY_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) (used_cnt == '0) |-> ret_valid == '0); // R4
    AST_NET_COUNT:     assert property (@(posedge clk) disable iff (!rst_n) rst_n && $past(rst_n) |-> used_cnt == $past(used_cnt) + CNT_W'($past(push)) - CNT_W'($past(ret_count))); // R9

endmodule

// File: tb/tb_completion_buffer.sv
`timescale 1ns/1ps
module tb_completion_buffer;

    localparam int DEPTH = 16;
    localparam int RET_W = 5;
    localparam int TAG_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [7:0]  alloc_tag = '0;
    logic [3:0]  alloc_idx;
    logic        alloc_err;
    logic [1:0]  cmpl_valid = '0;
    logic [7:0]  cmpl_idx = '0;
    logic [4:0]  ret_valid;
    logic [39:0] ret_tags;
    logic [2:0]  ret_count;
    logic [4:0]  free_cnt, used_cnt;
    logic        dispatch_stall;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // model
    int m_st[DEPTH];   // 0 empty, 1 waiting, 2 finished
    int m_tag[DEPTH];
    int m_head = 0, m_tail = 0, m_used = 0;

    always #2.5 clk = ~clk;

    completion_buffer dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
        .alloc_idx(alloc_idx), .alloc_err(alloc_err),
        .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
        .ret_valid(ret_valid), .ret_tags(ret_tags), .ret_count(ret_count),
        .free_cnt(free_cnt), .used_cnt(used_cnt), .dispatch_stall(dispatch_stall)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_retire_count();
        int n = 0;
        bit run = 1'b1;
        for (int k = 0; k < RET_W; k++) begin
            int s = (m_head + k) % DEPTH;
            run = run && (k < m_used) && (m_st[s] == 2);
            if (run) n++;
        end
        return n;
    endfunction

    // one cycle: drive, check the cycle's outputs against the model, advance the model
    task automatic step(input string req, input bit av, input int atag,
                        input bit c0v, input int c0i, input bit c1v, input int c1i);
        int n;
        int pre_st[DEPTH];
        @(negedge clk);
        alloc_valid = av;
        alloc_tag   = 8'(atag);
        cmpl_valid  = {c1v, c0v};
        cmpl_idx    = {4'(c1i), 4'(c0i)};
        #1;
        n = exp_retire_count();
        chk(req, "used_cnt R2", int'(used_cnt), m_used);
        chk(req, "free_cnt R10", int'(free_cnt), DEPTH - m_used);
        chk(req, "dispatch_stall R8", int'(dispatch_stall), int'(m_used == DEPTH));
        chk(req, "alloc_idx R2", int'(alloc_idx), m_tail);
        chk(req, "alloc_err R7", int'(alloc_err), int'(av && m_used == DEPTH));
        chk(req, "ret_count R5", int'(ret_count), n);
        for (int k = 0; k < RET_W; k++) begin
            chk(req, "ret_valid lane R4", int'(ret_valid[k]), int'(k < n));
            if (k < n)
                chk(req, "ret_tag lane R4", int'(ret_tags[k*TAG_W +: TAG_W]),
                    m_tag[(m_head + k) % DEPTH]);
        end
        for (int s = 0; s < DEPTH; s++) pre_st[s] = m_st[s];
        for (int k = 0; k < n; k++) begin
            m_st[(m_head + k) % DEPTH]  = 0;
            m_tag[(m_head + k) % DEPTH] = 0;
        end
        if (c0v && pre_st[c0i] == 1) m_st[c0i] = 2;
        if (c1v && pre_st[c1i] == 1) m_st[c1i] = 2;
        if (av && m_used < DEPTH) begin
            m_st[m_tail]  = 1;
            m_tag[m_tail] = atag & 8'hff;
            m_tail = (m_tail + 1) % DEPTH;
            m_used++;
        end
        m_head = (m_head + n) % DEPTH;
        m_used = m_used - n;
    endtask

    task automatic idle(input string req, input int cycles);
        for (int i = 0; i < cycles; i++) step(req, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int s = 0; s < DEPTH; s++) begin m_st[s] = 0; m_tag[s] = 0; end
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "used_cnt", int'(used_cnt), 0);
        chk("R1", "free_cnt", int'(free_cnt), 16);
        chk("R1", "dispatch_stall", int'(dispatch_stall), 0);
        chk("R1", "ret_valid", int'(ret_valid), 0);
        chk("R1", "alloc_idx", int'(alloc_idx), 0);

        // R2 allocation, R3 out-of-order finish, R4 head blocking, R6 next-cycle visibility
        step("R2", 1, 8'h11, 0, 0, 0, 0);
        step("R2", 1, 8'h22, 0, 0, 0, 0);
        step("R2", 1, 8'h33, 0, 0, 0, 0);
        step("R4", 0, 0, 1, 2, 1, 1);
        idle("R4", 2);
        step("R6", 0, 0, 1, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 0, 0);
        step("R3", 0, 0, 1, 5, 1, 9);
        idle("R3", 2);

        // R7/R8 fill to capacity and push one more; R5 drain of sixteen finished entries
        for (int i = 0; i < 17; i++) step("R7", 1, 8'h40 + i, 0, 0, 0, 0);
        for (int j = 15; j >= 1; j -= 2)
            step("R8", 1, 8'hee, 1, (m_head + j) % DEPTH, 1, (m_head + j - 1 + DEPTH) % DEPTH);
        step("R3", 1, 8'hef, 1, m_head, 1, m_head);
        step("R5", 1, 8'hf0, 0, 0, 0, 0);
        step("R5", 0, 0, 0, 0, 0, 0);
        step("R5", 0, 0, 0, 0, 0, 0);
        idle("R5", 2);

        // R9 allocation alongside retirement
        for (int i = 0; i < 6; i++) step("R9", 1, 8'h80 + i, 0, 0, 0, 0);
        step("R9", 1, 8'h90, 1, m_head, 1, (m_head + 1) % DEPTH);
        step("R9", 1, 8'h91, 1, (m_head + 2) % DEPTH, 1, (m_head + 3) % DEPTH);
        step("R9", 1, 8'h92, 0, 0, 0, 0);
        idle("R9", 2);

        // random mix, all requirements against the model (R9 label)
        for (int i = 0; i < 3000; i++) begin
            bit av  = ($urandom % 4) != 0;
            bit c0v = ($urandom % 5) < 3;
            bit c1v = ($urandom % 5) < 2;
            int c0i = (m_head + ($urandom % 16)) % DEPTH;
            int c1i = (m_head + ($urandom % 8)) % DEPTH;
            step("R9", av, int'($urandom % 256), c0v, c0i, c1v, c1i);
        end
        // finish everything still waiting, then drain (R10 at the end)
        for (int s = 0; s < DEPTH; s += 2) step("R10", 0, 0, 1, s, 1, s + 1);
        idle("R10", 6);
        chk("R10", "used_cnt drained", int'(used_cnt), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule